// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps a processor core's control-status registers and runs the entry and return steps for exceptions. Every cycle it combines 32 interrupt request lines with a software-written enable mask. It also watches two synchronous strobes, trap and unimplemented instruction. From these it decides whether an exception is taken in that same cycle. When one is taken, the block pulses a taken flag and reports a cause code. It presents a fixed handler vector and hands back the address of the following instruction, which the core writes to its exception-return register.

At the clock edge that closes a taken cycle, the current status is copied into a saved-status register. Both user mode and the global interrupt enable are then cleared. An exception-return strobe later puts the saved copy back into status. Six control registers sit behind a simple select/write/read port: status, saved status, break status, interrupt enable, interrupt pending and core identifier. The port works only while the core is in supervisor mode. All control pins are plain level or strobe signals sampled on every rising clock edge. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, the user-mode bit and the global interrupt enable are both 0 (supervisor mode, interrupts masked). The saved status, break status and interrupt enable registers read 0.
- R2: Register select 4 (pending) reads the bitwise AND of the request lines with the enable register, in the same cycle. A write to select 4 changes nothing.
- R3: An interrupt is taken (exc_taken=1, exc_cause=2'b01) only when status bit 0 (global enable) is 1 and at least one pending bit is set.
- R4: A trap strobe takes an exception with cause 2'b10. An unimplemented-instruction strobe takes one with cause 2'b11. Both do so whatever the global enable bit is. With no exception, the cause is 2'b00.
- R5: At the edge that ends a taken cycle, status is copied into the saved-status register (select 1), and status bits 1 (user) and 0 (global enable) are both cleared.
- R6: exc_vector always equals MEM_BASE + 0x20. In a taken cycle, exc_ret_addr equals next_pc; in other cycles it is 0.
- R7: An exception-return strobe with no exception in the same cycle loads status from the saved-status register at the next edge.
- R8: Status (select 0), saved status (select 1) and break status (select 2) hold only bits 1:0. Every other bit reads 0, and selects 6 and 7 read 0.
- R9: While status bit 1 is 1 (user mode), every control-register read returns 0 and every control-register write is ignored.
- R10: Priority order: interrupt over trap, trap over unimplemented instruction. An exception in a cycle overrides both an exception return and a register write in that cycle. An exception return overrides a register write in its cycle.
- R11: Select 3 writes and reads back the full enable mask. Select 5 reads the CORE_ID parameter, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level interrupt requests |
| trap_strobe | input | 1 | Software trap in this cycle |
| unimpl_strobe | input | 1 | Unimplemented instruction in this cycle |
| eret_strobe | input | 1 | Exception return in this cycle |
| next_pc | input | 32 | Address of the instruction after the current one |
| csr_sel | input | 3 | Control register select |
| csr_wr_en | input | 1 | Write strobe for the selected register |
| csr_wr_data | input | 32 | Write data |
| csr_rd_data | output | 32 | Read data of the selected register (combinational) |
| exc_taken | output | 1 | Exception taken this cycle |
| exc_cause | output | 2 | 00 none, 01 interrupt, 10 trap, 11 unimplemented |
| exc_vector | output | 32 | Handler entry address |
| exc_ret_addr | output | 32 | Value for the exception-return register |
| mode_user | output | 1 | Status bit 1: 1 user, 0 supervisor |
| irq_global_en | output | 1 | Status bit 0 |

## Verification
Directed patterns put each cause alone against the global enable. Requests that are raised but not enabled are told apart from enabled ones, and pending bits are shown to hide while the global enable is 0. Pairs and triples of simultaneous causes separate the priority order, including exception-return and register-write collisions. A user-mode excursion, entered through a status write and left through a trap, shows that reads return zero and writes are dropped. A long stretch of random requests, strobes and register accesses then checks saved/restored status chains against the reference model on every clock.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_IRQ    = 2'b01,
    CAUSE_TRAP   = 2'b10,
    CAUSE_UNIMPL = 2'b11
  } exc_cause_e;

  localparam int CSR_SEL_W = 3;

  typedef enum logic [CSR_SEL_W-1:0] {
    CSR_STATUS   = 3'd0,
    CSR_SAVED    = 3'd1,
    CSR_BRKSAVE  = 3'd2,
    CSR_IRQ_EN   = 3'd3,
    CSR_IRQ_PEND = 3'd4,
    CSR_CORE_ID  = 3'd5
  } csr_idx_e;

  localparam int ST_IE_BIT   = 0;
  localparam int ST_USER_BIT = 1;
  localparam int ST_W        = 2;

endpackage

// File: rtl/exc_pick.sv
module exc_pick
  import exc_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_ie,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic               trap,
  input  logic               unimpl,
  output logic               taken,
  output exc_cause_e         cause
);

  logic irq_go;

  always_comb begin
    irq_go = glob_ie && (|pend);
    if (irq_go)      cause = CAUSE_IRQ;
    else if (trap)   cause = CAUSE_TRAP;
    else if (unimpl) cause = CAUSE_UNIMPL;
    else             cause = CAUSE_NONE;
    taken = (cause != CAUSE_NONE);
  end

  // R10: interrupt wins over synchronous causes
  assert_irq_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_ie && (|pend) && (trap || unimpl)) |-> (cause == CAUSE_IRQ));

  // R3: an interrupt entry masks further interrupts on the next cycle
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == CAUSE_IRQ) |=> (cause != CAUSE_IRQ));

  // R4: a synchronous strobe is never lost
  assert_sync_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap || unimpl) |-> taken);

endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
  import exc_ctrl_pkg::*;
#(
  parameter int               XLEN    = 32,
  parameter int               NUM_IRQ = 32,
  parameter logic [XLEN-1:0]  CORE_ID = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_lines,
  input  logic                 take,
  input  logic                 eret,
  input  logic                 wr_en,
  input  logic [CSR_SEL_W-1:0] sel,
  input  logic [XLEN-1:0]      wr_data,
  output logic [XLEN-1:0]      rd_data,
  output logic [NUM_IRQ-1:0]   pend,
  output logic [ST_W-1:0]      status
);

  logic [ST_W-1:0]    status_q, saved_q, brk_q;
  logic [NUM_IRQ-1:0] ien_q;
  logic               priv_ok;
  logic               wr_ok;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_pend
    assign pend[k] = irq_lines[k] & ien_q[k];
  end

  assign priv_ok = !status_q[ST_USER_BIT];
  assign wr_ok   = wr_en && priv_ok && !take && !eret;
  assign status  = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      saved_q  <= '0;
      brk_q    <= '0;
      ien_q    <= '0;
    end else if (take) begin
      saved_q  <= status_q;
      status_q <= '0;
    end else if (eret) begin
      status_q <= saved_q;
    end else if (wr_ok) begin
      case (csr_idx_e'(sel))
        CSR_STATUS:  status_q <= wr_data[ST_W-1:0];
        CSR_SAVED:   saved_q  <= wr_data[ST_W-1:0];
        CSR_BRKSAVE: brk_q    <= wr_data[ST_W-1:0];
        CSR_IRQ_EN:  ien_q    <= wr_data[NUM_IRQ-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (priv_ok) begin
      case (csr_idx_e'(sel))
        CSR_STATUS:   rd_data[ST_W-1:0]    = status_q;
        CSR_SAVED:    rd_data[ST_W-1:0]    = saved_q;
        CSR_BRKSAVE:  rd_data[ST_W-1:0]    = brk_q;
        CSR_IRQ_EN:   rd_data[NUM_IRQ-1:0] = ien_q;
        CSR_IRQ_PEND: rd_data[NUM_IRQ-1:0] = pend;
        CSR_CORE_ID:  rd_data              = CORE_ID;
        default:      rd_data              = '0;
      endcase
    end
  end

  // R5: entry saves status and drops to masked supervisor mode
  assert_entry_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (saved_q == $past(status_q)) && (status_q == '0));

  // R7: return restores status from the saved copy
  assert_return_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> (status_q == $past(saved_q)));

  // R9: no register write lands while in user mode
  assert_user_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[ST_USER_BIT] && !take && !eret) |=>
      ($stable(ien_q) && $stable(saved_q) && $stable(brk_q) && $stable(status_q)));

  // R9: reads are blanked in user mode
  assert_user_noread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[ST_USER_BIT] |-> (rd_data == '0));

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_ctrl_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              NUM_IRQ  = 32,
  parameter logic [XLEN-1:0] MEM_BASE = 32'h0800_0000,
  parameter logic [XLEN-1:0] CORE_ID  = 32'h0000_0A5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_lines,
  input  logic                 trap_strobe,
  input  logic                 unimpl_strobe,
  input  logic                 eret_strobe,
  input  logic [XLEN-1:0]      next_pc,
  input  logic [CSR_SEL_W-1:0] csr_sel,
  input  logic                 csr_wr_en,
  input  logic [XLEN-1:0]      csr_wr_data,
  output logic [XLEN-1:0]      csr_rd_data,
  output logic                 exc_taken,
  output logic [1:0]           exc_cause,
  output logic [XLEN-1:0]      exc_vector,
  output logic [XLEN-1:0]      exc_ret_addr,
  output logic                 mode_user,
  output logic                 irq_global_en
);

  localparam logic [XLEN-1:0] VEC_OFFSET = XLEN'(32'h20);
  localparam logic [XLEN-1:0] HANDLER_AT = MEM_BASE + VEC_OFFSET;

  logic [NUM_IRQ-1:0] pend;
  logic [ST_W-1:0]    status;
  logic               taken;
  exc_cause_e         cause;

  exc_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .glob_ie (status[ST_IE_BIT]),
    .pend    (pend),
    .trap    (trap_strobe),
    .unimpl  (unimpl_strobe),
    .taken   (taken),
    .cause   (cause)
  );

  exc_csr_bank #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .CORE_ID(CORE_ID)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .take      (taken),
    .eret      (eret_strobe),
    .wr_en     (csr_wr_en),
    .sel       (csr_sel),
    .wr_data   (csr_wr_data),
    .rd_data   (csr_rd_data),
    .pend      (pend),
    .status    (status)
  );

  assign exc_taken     = taken;
  assign exc_cause     = cause;
  assign exc_vector    = HANDLER_AT;
  assign exc_ret_addr  = taken ? next_pc : '0;
  assign mode_user     = status[ST_USER_BIT];
  assign irq_global_en = status[ST_IE_BIT];

  // R6: return address is driven only during a taken cycle
  assert_ret_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |-> (exc_ret_addr == '0));

  // R5: the cycle after any entry is masked supervisor mode
  assert_entry_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> (!mode_user && !irq_global_en));

endmodule

// File: tb/exc_ctrl_unit_test.sv
module exc_ctrl_unit_test;

  localparam logic [31:0] BASE = 32'h0800_0000;
  localparam logic [31:0] CID  = 32'h0000_0A5C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        trap_strobe = 1'b0, unimpl_strobe = 1'b0, eret_strobe = 1'b0;
  logic [31:0] next_pc = '0;
  logic [2:0]  csr_sel = '0;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic [31:0] csr_rd_data, exc_vector, exc_ret_addr;
  logic        exc_taken, mode_user, irq_global_en;
  logic [1:0]  exc_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [1:0]  m_status = '0, m_saved = '0, m_brk = '0;
  logic [31:0] m_en = '0;

  exc_ctrl_unit #(.MEM_BASE(BASE), .CORE_ID(CID)) uut (
    .clk, .rst_n, .irq_lines, .trap_strobe, .unimpl_strobe, .eret_strobe,
    .next_pc, .csr_sel, .csr_wr_en, .csr_wr_data, .csr_rd_data,
    .exc_taken, .exc_cause, .exc_vector, .exc_ret_addr,
    .mode_user, .irq_global_en
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] m_cause();
    logic [31:0] p;
    p = irq_lines & m_en;
    if (m_status[0] && (p != 0)) return 2'b01;
    if (trap_strobe)             return 2'b10;
    if (unimpl_strobe)           return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [31:0] m_read();
    if (m_status[1]) return '0;
    case (csr_sel)
      3'd0: return {30'd0, m_status};
      3'd1: return {30'd0, m_saved};
      3'd2: return {30'd0, m_brk};
      3'd3: return m_en;
      3'd4: return irq_lines & m_en;
      3'd5: return CID;
      default: return '0;
    endcase
  endfunction

  // called just after a falling edge with inputs set
  task automatic cyc();
    logic [1:0] c;
    #8;
    c = m_cause();
    chk(exc_cause == c, "R3 R4 R10 cause", {30'd0, exc_cause}, {30'd0, c});
    chk(exc_taken == (c != 0), "R3 R4 taken", {31'd0, exc_taken}, {31'd0, c != 0});
    chk(exc_vector == BASE + 32'h20, "R6 vector", exc_vector, BASE + 32'h20);
    chk(exc_ret_addr == ((c != 0) ? next_pc : 32'd0), "R6 return address",
        exc_ret_addr, (c != 0) ? next_pc : 32'd0);
    chk(csr_rd_data == m_read(), "R2 R8 R9 R11 readback", csr_rd_data, m_read());
    chk({mode_user, irq_global_en} == m_status, "R1 R5 R7 mode",
        {30'd0, mode_user, irq_global_en}, {30'd0, m_status});
    @(posedge clk);
    if (c != 0) begin
      m_saved  = m_status;
      m_status = '0;
    end else if (eret_strobe) begin
      m_status = m_saved;
    end else if (csr_wr_en && !m_status[1]) begin
      case (csr_sel)
        3'd0: m_status = csr_wr_data[1:0];
        3'd1: m_saved  = csr_wr_data[1:0];
        3'd2: m_brk    = csr_wr_data[1:0];
        3'd3: m_en     = csr_wr_data;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    trap_strobe = 0; unimpl_strobe = 0; eret_strobe = 0; csr_wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    csr_sel = s; csr_wr_data = d; csr_wr_en = 1; cyc(); csr_wr_en = 0;
  endtask

  task automatic rd_expect(input logic [2:0] s, input logic [31:0] e, input string req);
    csr_sel = s; #8;
    chk(csr_rd_data == e, req, csr_rd_data, e);
    #2; @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R11 identifier
    chk({mode_user, irq_global_en} == 2'b00, "R1 reset mode", {30'd0, mode_user, irq_global_en}, 0);
    rd_expect(3'd1, 0, "R1 saved after reset");
    rd_expect(3'd2, 0, "R1 break after reset");
    rd_expect(3'd3, 0, "R1 enable after reset");
    rd_expect(3'd5, CID, "R11 core id");
    // R11 enable mask, R8 narrow registers
    wr(3'd3, 32'hFFFF_00F0);
    rd_expect(3'd3, 32'hFFFF_00F0, "R11 enable readback");
    wr(3'd1, 32'hFFFF_FFFF);
    rd_expect(3'd1, 32'h3, "R8 saved width");
    wr(3'd2, 32'hFFFF_FFFE);
    rd_expect(3'd2, 32'h2, "R8 break width");
    wr(3'd5, 32'h1234_5678);
    rd_expect(3'd5, CID, "R11 core id write ignored");
    rd_expect(3'd6, 0, "R8 unused select");
    wr(3'd0, 32'hFFFF_FFFD);
    rd_expect(3'd0, 32'h1, "R8 status width");
    // R3: raised but not enabled requests
    irq_lines = 32'h0000_000F; next_pc = 32'h100; cyc();
    chk(exc_taken == 0, "R3 masked request", {31'd0, exc_taken}, 0);
    // R3: enabled request while global enable on
    irq_lines = 32'h0000_0010; next_pc = 32'h104; cyc();
    irq_lines = 32'h0000_0010; cyc();
    chk(exc_taken == 0, "R3 no retake after entry", {31'd0, exc_taken}, 0);
    rd_expect(3'd1, 32'h1, "R5 saved status");
    // R2 pending readback and write ignored
    irq_lines = 32'h0000_3030;
    rd_expect(3'd4, 32'h0000_0030, "R2 pending value");
    wr(3'd4, 32'hFFFF_FFFF);
    rd_expect(3'd4, 32'h0000_0030, "R2 pending after write");
    rd_expect(3'd3, 32'hFFFF_00F0, "R2 enable untouched");
    irq_lines = 0;
    // R7 return
    eret_strobe = 1; cyc(); idle();
    chk(irq_global_en == 1, "R7 restored enable", {31'd0, irq_global_en}, 1);
    // R4 strobes with global enable off
    wr(3'd0, 0);
    trap_strobe = 1; next_pc = 32'h200; cyc(); idle();
    unimpl_strobe = 1; next_pc = 32'h204; cyc(); idle();
    trap_strobe = 1; unimpl_strobe = 1; cyc(); idle();
    // R10 interrupt beats trap
    wr(3'd0, 1);
    irq_lines = 32'h8000_0000; trap_strobe = 1; next_pc = 32'h300; cyc(); idle();
    irq_lines = 0;
    // R10 exception beats return and write
    wr(3'd1, 32'h3);
    trap_strobe = 1; eret_strobe = 1; cyc(); idle();
    chk(mode_user == 0, "R10 trap over return", {31'd0, mode_user}, 0);
    eret_strobe = 1; csr_wr_en = 1; csr_sel = 3'd3; csr_wr_data = 0; cyc(); idle();
    chk(irq_global_en == 0, "R10 return restores zero saved", {31'd0, irq_global_en}, 0);
    rd_expect(3'd3, 32'hFFFF_00F0, "R10 write lost to return");
    // R9 user mode excursion
    wr(3'd0, 32'h2);
    chk(mode_user == 1, "R9 entered user", {31'd0, mode_user}, 1);
    rd_expect(3'd5, 0, "R9 read blanked");
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0);
    chk(mode_user == 1, "R9 status write ignored", {31'd0, mode_user}, 1);
    trap_strobe = 1; next_pc = 32'h400; cyc(); idle();
    rd_expect(3'd3, 32'hFFFF_00F0, "R9 enable kept");
    rd_expect(3'd1, 32'h2, "R5 saved user mode");
    // R7 return into user with interrupts on, then interrupt from user
    wr(3'd1, 32'h3);
    eret_strobe = 1; cyc(); idle();
    chk(mode_user == 1 && irq_global_en == 1, "R7 user restore",
        {30'd0, mode_user, irq_global_en}, 3);
    irq_lines = 32'h0001_0000; next_pc = 32'h500; cyc();
    irq_lines = 0;
    rd_expect(3'd1, 32'h3, "R5 saved from user");
    // random phase
    for (int i = 0; i < 1500; i++) begin
      irq_lines     = $urandom & $urandom & $urandom;
      trap_strobe   = ($urandom % 10) == 0;
      unimpl_strobe = ($urandom % 12) == 0;
      eret_strobe   = ($urandom % 9) == 0;
      csr_wr_en     = ($urandom % 3) == 0;
      csr_sel       = 3'($urandom % 8);
      csr_wr_data   = $urandom;
      next_pc       = $urandom & 32'hFFFF_FFFC;
      cyc();
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule